// File: doc/BRIEF.md
# Two-Wire Bus Recovery Sequencer

This block sits beside a two-wire bus master and frees a bus that a slave has left stuck. That can happen after a transfer is cut short, after a power dip or after a reset. The usual symptom is a slave that holds the data line low while it waits for clock edges it never received. When software or a supervisor raises the recovery request, the sequencer takes over both lines with open-drain drive: it only pulls a line low or lets it go, and pull-up resistors supply the high level. It toggles the clock line at a configurable half-period and looks at the data line near the end of every high phase. It stops clocking as soon as the data line reads high.

Once the line is free, the sequencer waits for a bus-free interval. It then creates a start condition (data falls while clock is high) and holds it, takes the clock low, and closes with a stop condition (data rises while clock is high). This leaves every slave's protocol logic reset and the bus idle. If the data line is still low after the last allowed pulse, the sequencer releases both lines and reports failure instead. All timing is set in system clock cycles.

Top module: `bus_unjam_seq`

## Requirements
- R1: After a synchronous reset, both pull outputs are 0 (lines released), and busy, done and fail are 0.
- R2: While clocking, each clock-line low phase lasts exactly HALF_CYC system clock cycles, and so does each high phase.
- R3: The data line, passed through an input synchronizer, is sampled at the end of each clock high phase. Clocking stops after the first high phase in which it reads 1. At most MAX_PULSES clock pulses are issued before a start or a failure.
- R4: After the data line is seen high, both lines stay released for at least BUF_CYC cycles. A start condition follows: sda_pull rises while scl_pull is 0. The start is held for exactly HOLD_CYC cycles before scl_pull rises, and exactly one start is produced per successful recovery.
- R5: The sequence ends with a stop condition: sda_pull falls while scl_pull is 0. After BUF_CYC more idle cycles, busy falls with done at 1, and both lines are released whenever busy is 0.
- R6: If the data line still reads 0 at the end of the high phase of pulse MAX_PULSES, fail is set, busy falls, both lines are released and no start condition is generated.
- R7: A recovery request that arrives while busy is 1 is ignored. The running sequence keeps its pulse count and outcome.
- R8: A request accepted while idle sets busy on the next clock edge and clears done and fail on that same edge. done and fail are never both 1, and each one holds until the next accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| recover_req | input | 1 | Start a recovery sequence (sampled only while idle) |
| sda_in | input | 1 | Level of the data line on the bus |
| scl_pull | output | 1 | 1 = pull the clock line low, 0 = release it |
| sda_pull | output | 1 | 1 = pull the data line low, 0 = release it |
| busy | output | 1 | A recovery sequence is running |
| done | output | 1 | The last sequence freed the bus and ended with a stop |
| fail | output | 1 | The last sequence gave up with the data line still low |

## Verification
On every cycle the assertions check four things. The data pull changes only while the clock line is released, so its edges are always start or stop conditions. Both lines are released whenever the block is idle or has failed. done and fail never coincide, and both are cleared when a new sequence is accepted. A counter in the checker also bounds the number of clock pulses in a sequence. Other properties need a modelled slave that releases the line after a chosen number of pulses, so only the bench scenarios can show them. These are the exact pulse count, the measured phase lengths, the start hold and bus-free intervals, the failure path, and a request ignored in mid-sequence.

// File: rtl/unjam_pkg.sv
package unjam_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,    // lines released, waiting for a request
    ST_LOW,     // clock pulled low
    ST_HIGH,    // clock released, data checked at end
    ST_FREE,    // bus-free wait before start
    ST_START,   // data low, clock high: start hold
    ST_SCLDN,   // clock low, data low
    ST_STOPSU,  // clock high, data low: stop setup
    ST_POST     // both released after stop
  } unjam_state_e;

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/unjam_sync.sv
module unjam_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] shreg;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) shreg <= '1;
        else     shreg <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) shreg <= '1;   // idle bus reads high
        else     shreg <= {shreg[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = shreg[STAGES-1];
endmodule

// File: rtl/unjam_timer.sv
module unjam_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst)                remain <= '0;
    else if (load)          remain <= load_val;
    else if (remain != '0)  remain <= remain - 1'b1;
  end

  assign expired = (remain == '0);
endmodule

// File: rtl/unjam_fsm.sv
module unjam_fsm
  import unjam_pkg::*;
#(
  parameter int HALF_CYC   = 4,
  parameter int BUF_CYC    = 6,
  parameter int HOLD_CYC   = 5,
  parameter int MAX_PULSES = 9,
  parameter int CNT_W      = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic             sda_high,
  input  logic             tmr_exp,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             scl_pull,
  output logic             sda_pull,
  output logic             busy,
  output logic             done,
  output logic             fail
);
  localparam int PC_W = $clog2(MAX_PULSES + 1);
  localparam logic [CNT_W-1:0] HALF_M1 = CNT_W'(HALF_CYC - 1);
  localparam logic [CNT_W-1:0] BUF_M1  = CNT_W'(BUF_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_M1 = CNT_W'(HOLD_CYC - 1);
  localparam logic [PC_W-1:0]  PC_MAX  = PC_W'(MAX_PULSES);

  unjam_state_e     state_q, state_d;
  logic [PC_W-1:0]  pulses_q, pulses_d;
  logic             done_d, fail_d;

  always_comb begin
    state_d  = state_q;
    pulses_d = pulses_q;
    done_d   = done;
    fail_d   = fail;
    tmr_load = 1'b0;
    tmr_val  = HALF_M1;
    unique case (state_q)
      ST_IDLE: begin
        if (req) begin
          state_d  = ST_LOW;
          pulses_d = '0;
          done_d   = 1'b0;
          fail_d   = 1'b0;
          tmr_load = 1'b1;
          tmr_val  = HALF_M1;
        end
      end
      ST_LOW: begin
        if (tmr_exp) begin
          state_d  = ST_HIGH;
          pulses_d = pulses_q + 1'b1;
          tmr_load = 1'b1;
          tmr_val  = HALF_M1;
        end
      end
      ST_HIGH: begin
        if (tmr_exp) begin
          tmr_load = 1'b1;
          if (sda_high) begin
            state_d = ST_FREE;
            tmr_val = BUF_M1;
          end else if (pulses_q >= PC_MAX) begin
            state_d = ST_IDLE;
            fail_d  = 1'b1;
          end else begin
            state_d = ST_LOW;
            tmr_val = HALF_M1;
          end
        end
      end
      ST_FREE: begin
        if (tmr_exp) begin
          state_d  = ST_START;
          tmr_load = 1'b1;
          tmr_val  = HOLD_M1;
        end
      end
      ST_START: begin
        if (tmr_exp) begin
          state_d  = ST_SCLDN;
          tmr_load = 1'b1;
          tmr_val  = HALF_M1;
        end
      end
      ST_SCLDN: begin
        if (tmr_exp) begin
          state_d  = ST_STOPSU;
          tmr_load = 1'b1;
          tmr_val  = HALF_M1;
        end
      end
      ST_STOPSU: begin
        if (tmr_exp) begin
          state_d  = ST_POST;
          tmr_load = 1'b1;
          tmr_val  = BUF_M1;
        end
      end
      ST_POST: begin
        if (tmr_exp) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // State and registered line drive, decoded from the next state
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      pulses_q <= '0;
      scl_pull <= 1'b0;
      sda_pull <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
      fail     <= 1'b0;
    end else begin
      state_q  <= state_d;
      pulses_q <= pulses_d;
      scl_pull <= (state_d == ST_LOW) || (state_d == ST_SCLDN);
      sda_pull <= (state_d == ST_START) || (state_d == ST_SCLDN) ||
                  (state_d == ST_STOPSU);
      busy     <= (state_d != ST_IDLE);
      done     <= done_d;
      fail     <= fail_d;
    end
  end
endmodule

// File: rtl/bus_unjam_seq.sv
module bus_unjam_seq
  import unjam_pkg::*;
#(
  parameter int HALF_CYC    = 4,
  parameter int BUF_CYC     = 6,
  parameter int HOLD_CYC    = 5,
  parameter int MAX_PULSES  = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic recover_req,
  input  logic sda_in,
  output logic scl_pull,
  output logic sda_pull,
  output logic busy,
  output logic done,
  output logic fail
);
  localparam int MAX_LEN = int'(max3(HALF_CYC, BUF_CYC, HOLD_CYC));
  localparam int CNT_W   = (MAX_LEN < 2) ? 1 : $clog2(MAX_LEN);

  logic             sda_high;
  logic             tmr_load;
  logic             tmr_exp;
  logic [CNT_W-1:0] tmr_val;

  unjam_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk (clk),
    .rst (rst),
    .d   (sda_in),
    .q   (sda_high)
  );

  unjam_timer #(.CNT_W(CNT_W)) i_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_exp)
  );

  unjam_fsm #(
    .HALF_CYC   (HALF_CYC),
    .BUF_CYC    (BUF_CYC),
    .HOLD_CYC   (HOLD_CYC),
    .MAX_PULSES (MAX_PULSES),
    .CNT_W      (CNT_W)
  ) i_fsm (
    .clk      (clk),
    .rst      (rst),
    .req      (recover_req),
    .sda_high (sda_high),
    .tmr_exp  (tmr_exp),
    .tmr_load (tmr_load),
    .tmr_val  (tmr_val),
    .scl_pull (scl_pull),
    .sda_pull (sda_pull),
    .busy     (busy),
    .done     (done),
    .fail     (fail)
  );
endmodule

// File: rtl/unjam_checker.sv
module unjam_checker #(
  parameter int MAX_PULSES = 9
) (
  input logic clk,
  input logic rst,
  input logic scl_pull,
  input logic sda_pull,
  input logic busy,
  input logic done,
  input logic fail
);
  logic        scl_prev;
  logic [15:0] pulse_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_prev  <= 1'b0;
      pulse_cnt <= '0;
    end else begin
      scl_prev <= scl_pull;
      if (!busy)                     pulse_cnt <= '0;
      else if (scl_pull && !scl_prev) pulse_cnt <= pulse_cnt + 1'b1;
    end
  end

  // R3: recovery pulses plus the one clock-low after the start
  assert_pulse_bound_R3: assert property (@(posedge clk) disable iff (rst)
    pulse_cnt <= 16'(MAX_PULSES + 1));

  assert_start_edge_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_pull) |-> !scl_pull);

  assert_stop_edge_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(sda_pull) |-> !scl_pull);

  assert_idle_released_R5: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!scl_pull && !sda_pull));

  assert_fail_released_R6: assert property (@(posedge clk) disable iff (rst)
    fail |-> (!busy && !scl_pull && !sda_pull));

  assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
    !(done && fail));

  assert_flags_cleared_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (!done && !fail));
endmodule

bind bus_unjam_seq unjam_checker #(.MAX_PULSES(MAX_PULSES)) i_chk (
  .clk      (clk),
  .rst      (rst),
  .scl_pull (scl_pull),
  .sda_pull (sda_pull),
  .busy     (busy),
  .done     (done),
  .fail     (fail)
);

// File: tb/test_bus_unjam_seq.sv
module test_bus_unjam_seq;
  localparam int HALF = 4;
  localparam int BUFC = 6;
  localparam int HOLD = 5;
  localparam int MAXP = 9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic recover_req = 1'b0;
  logic scl_pull, sda_pull, busy, done, fail;
  logic sda_line;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // bus and slave model
  int  slave_k = 0;
  logic mon_clr = 1'b1;
  int  falls, low_bad, starts, stops, free_len, hold_run, hold_len, pulses_at_start;
  int  low_run, both_run;
  bit  hold_open;
  logic prev_scl = 1'b1, prev_sda = 1'b1;
  logic slave_low;

  assign slave_low = (falls < slave_k);
  assign sda_line  = !(sda_pull || slave_low);

  always #10 clk = ~clk;

  bus_unjam_seq #(.HALF_CYC(HALF), .BUF_CYC(BUFC), .HOLD_CYC(HOLD),
                  .MAX_PULSES(MAXP), .SYNC_STAGES(2)) i_bus_unjam_seq (
    .clk(clk), .rst(rst), .recover_req(recover_req), .sda_in(sda_line),
    .scl_pull(scl_pull), .sda_pull(sda_pull), .busy(busy), .done(done), .fail(fail));

  always @(negedge clk) begin
    logic scl_l, sda_l;
    scl_l = !scl_pull;
    sda_l = sda_line;
    if (mon_clr) begin
      falls = 0; low_bad = 0; starts = 0; stops = 0; free_len = 0;
      hold_run = 0; hold_len = 0; pulses_at_start = 0; low_run = 0;
      both_run = 0; hold_open = 0;
    end else begin
      if (prev_scl && !scl_l) begin
        falls++;
        if (hold_open) begin hold_len = hold_run; hold_open = 0; end
      end
      if (!prev_scl && scl_l && low_run != HALF) low_bad++;
      if (prev_scl && scl_l && prev_sda && !sda_l) begin
        starts++; free_len = both_run; pulses_at_start = falls;
        hold_open = 1; hold_run = 0;
      end
      if (prev_scl && scl_l && !prev_sda && sda_l) stops++;
      if (hold_open && scl_l && !sda_l) hold_run++;
      if (!scl_l) low_run++; else low_run = 0;
      if (scl_l && sda_l) both_run++; else both_run = 0;
    end
    prev_scl = scl_l;
    prev_sda = sda_l;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_idle();
    int n = 0;
    @(negedge clk);
    while (busy && n < 3000) begin @(negedge clk); n++; end
    check(n < 3000, "R5 sequence completes", n, 3000);
  endtask

  task automatic setup_slave(input int k);
    @(posedge clk); #2;
    mon_clr = 1'b1; slave_k = k;
    repeat (3) @(posedge clk);
    #2 mon_clr = 1'b0;
  endtask

  task automatic pulse_req();
    @(posedge clk); #2 recover_req = 1'b1;
    @(posedge clk); #2 recover_req = 1'b0;
  endtask

  task automatic test_reset();
    @(negedge clk);
    check(scl_pull == 0, "R1 scl released", scl_pull, 0);
    check(sda_pull == 0, "R1 sda released", sda_pull, 0);
    check(busy == 0, "R1 busy", busy, 0);
    check(done == 0 && fail == 0, "R1 flags", {done, fail}, 0);
  endtask

  task automatic test_recover(input int k, input bit mid_req);
    int expp = (k < 1) ? 1 : k;
    setup_slave(k);
    pulse_req();
    @(negedge clk);
    check(busy == 1, "R8 busy after request", busy, 1);
    check(done == 0 && fail == 0, "R8 flags cleared", {done, fail}, 0);
    if (mid_req) begin
      repeat (10) @(posedge clk);
      pulse_req();   // R7: must be ignored
    end
    wait_idle();
    check(pulses_at_start == expp, "R3 pulses before start", pulses_at_start, expp);
    check(low_bad == 0, "R2 low phase length", low_bad, 0);
    check(starts == 1, "R4 single start", starts, 1);
    check(hold_len == HOLD, "R4 start hold", hold_len, HOLD);
    check(free_len >= BUFC, "R4 bus free", free_len, BUFC);
    check(stops == 1, "R5 single stop", stops, 1);
    check(done == 1 && fail == 0, "R5 done set", {done, fail}, 2);
    if (mid_req) check(falls == expp + 1, "R7 mid request ignored", falls, expp + 1);
    repeat (5) @(negedge clk);
    check(done == 1 && !scl_pull && !sda_pull, "R8 done holds, lines released",
          {done, scl_pull, sda_pull}, 4);
  endtask

  task automatic test_fail();
    setup_slave(MAXP + 1);
    pulse_req();
    wait_idle();
    check(fail == 1 && done == 0, "R6 fail set", {done, fail}, 1);
    check(falls == MAXP, "R6 pulses issued", falls, MAXP);
    check(starts == 0, "R6 no start", starts, 0);
    check(low_bad == 0, "R2 low phase length", low_bad, 0);
    check(!scl_pull && !sda_pull, "R6 released", {scl_pull, sda_pull}, 0);
    repeat (5) @(negedge clk);
    check(fail == 1, "R8 fail holds", fail, 1);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #2 rst = 1'b0;
    test_reset();
    test_recover(3, 0);
    test_recover(0, 0);
    test_recover(MAXP, 0);
    test_fail();
    test_recover(2, 0);   // also clears prior fail (R8)
    test_recover(4, 1);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog R5 actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule